// File: doc/BRIEF.md
# Sixteen-Channel Edge-Placed PWM Generator

This block produces sixteen pulse-width-modulated outputs from one shared time base. A prescaler divides the input clock, and its ticks drive a step counter that runs from zero up to a programmed period value and then starts again. Each channel holds two step positions: the step at which its output goes high and the step at which it goes low. The order of the two positions sets the polarity. If the high-going step comes first, the result is an ordinary pulse. If the low-going step comes first, the result is a notch in an otherwise high output. If the two are equal, the output stays low.

Software configures the block through a simple APB-style register port with byte-wide registers on word-aligned offsets. Writes to the time base and edge registers land in shadow copies. A synchronous-update control bit selects when those copies reach the active set. With the bit clear, they take effect on the next clock. With the bit set, they take effect at the end of the current period, so the output never shows a period that mixes old and new values. Enable bits take effect directly. Turning a channel on lets it join the running counter instead of restarting it.

Top module: `pwm_edge_ctrl`

## Requirements
- R1: After reset, every register reads zero and every pwm_out bit is low.
- R2: Register offsets: 0x00 prescale, 0x04 period, 0x08 enables for channels 0..7 (bit k = channel k), 0x0C enables for channels 8..15 (bit k = channel 8+k), 0x10+8n rise step of channel n, 0x14+8n fall step of channel n, 0xE4 sync-update (bit 0 only; bits 7..1 read zero). Each register reads back the value last written to it.
- R3: A read from any other offset, including offsets that are not word aligned, returns zero. A write to such an offset changes no register.
- R4: The step counter advances once every prescale+1 clocks and returns to zero after it reaches the period value. One output period is therefore (prescale+1)*(period+1) clocks long.
- R5: When rise < fall (both no greater than period), the output is high during steps rise through fall-1, which is (fall-rise)*(prescale+1) clocks per period.
- R6: When fall < rise, the output is low during steps fall through rise-1 and high for the rest of the period, which is (period+1-(rise-fall))*(prescale+1) clocks.
- R7: When rise equals fall, the channel output stays low.
- R8: A channel whose enable bit is clear drives its output low.
- R9: A channel that is enabled in the middle of a period follows the shared counter phase. Its edges land on the same clocks as those of an already running channel with the same edge values.
- R10: With sync-update clear, a written prescale, period or edge value reaches the active set on the clock after the write.
- R11: With sync-update set, written prescale, period and edge values reach the active set only at the last clock of the running period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Register port select |
| penable | input | 1 | Access phase; a write commits when psel, penable and pwrite are all high |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 8 | Byte offset of the register |
| pwdata | input | 8 | Write data |
| prdata | output | 8 | Read data for paddr (combinational) |
| pwm_out | output | 16 | Channel outputs, registered |

## Verification
On every clock, the assertions check the following: disabled channels are low, channels with equal edges are low, the step counter moves only on a prescaler tick and returns to zero after each period end, the active set follows the shadow set in immediate mode, and the active set holds steady in sync mode except at a period end. Only the bench scenarios can show the following: the measured period and high time for both edge orders and several prescale settings, the register map and its readback, and the handling of unmapped offsets. The bench scenarios also show the visible difference between the two update modes when a fall step moves in the middle of a pulse, and a late-enabled channel lining up with a running one.

// File: rtl/pwm_edge_pkg.sv
package pwm_edge_pkg;

    parameter int PWM_DW    = 8;   // register and step width
    parameter int PWM_AW    = 8;   // byte offset width
    parameter int PWM_GRP_W = 8;   // channels per enable register

    localparam int OFS_PRESC   = 'h00;
    localparam int OFS_PERIOD  = 'h04;
    localparam int OFS_EN_BASE = 'h08;
    localparam int OFS_EN_STEP = 4;
    localparam int OFS_EDGE    = 'h10;
    localparam int EDGE_STRIDE = 8;
    localparam int FALL_OFS    = 4;
    localparam int OFS_SYNC    = 'hE4;

    typedef logic [PWM_DW-1:0] pwm_val_t;

    typedef struct packed {
        pwm_val_t presc;
        pwm_val_t period;
    } pwm_tb_cfg_t;

    typedef struct packed {
        pwm_val_t rise;
        pwm_val_t fall;
    } pwm_edges_t;

    function automatic logic addr_hit(logic [PWM_AW-1:0] a, int ofs);
        return a == PWM_AW'(ofs);
    endfunction

    // Output level for one step position given an edge pair.
    function automatic logic pwm_level(pwm_val_t step, pwm_edges_t e);
        if (e.rise < e.fall)
            return (step >= e.rise) && (step < e.fall);
        else if (e.fall < e.rise)
            return (step >= e.rise) || (step < e.fall);
        else
            return 1'b0;
    endfunction

endpackage

// File: rtl/pwm_edge_regs.sv
module pwm_edge_regs
    import pwm_edge_pkg::*;
#(
    parameter int NUM_CH  = 16,
    parameter int NUM_GRP = 2
)(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [PWM_AW-1:0]             addr,
    input  pwm_val_t                      wdata,
    output pwm_val_t                      rdata,
    output pwm_tb_cfg_t                   shd_tb,
    output pwm_edges_t [NUM_CH-1:0]       shd_edges,
    output logic [NUM_CH-1:0]             chan_en,
    output logic                          sync_mode
);

    localparam int EN_W = NUM_GRP * PWM_GRP_W;

    logic [EN_W-1:0] en_q;

    assign chan_en = en_q[NUM_CH-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            shd_tb    <= '0;
            shd_edges <= '0;
            en_q      <= '0;
            sync_mode <= 1'b0;
        end else if (wr_en) begin
            if (addr_hit(addr, OFS_PRESC))  shd_tb.presc  <= wdata;
            if (addr_hit(addr, OFS_PERIOD)) shd_tb.period <= wdata;
            if (addr_hit(addr, OFS_SYNC))   sync_mode     <= wdata[0];
            for (int g = 0; g < NUM_GRP; g++) begin
                if (addr_hit(addr, OFS_EN_BASE + g * OFS_EN_STEP))
                    en_q[g*PWM_GRP_W +: PWM_GRP_W] <= wdata;
            end
            for (int ch = 0; ch < NUM_CH; ch++) begin
                if (addr_hit(addr, OFS_EDGE + ch * EDGE_STRIDE))
                    shd_edges[ch].rise <= wdata;
                if (addr_hit(addr, OFS_EDGE + ch * EDGE_STRIDE + FALL_OFS))
                    shd_edges[ch].fall <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr_hit(addr, OFS_PRESC))  rdata = shd_tb.presc;
        if (addr_hit(addr, OFS_PERIOD)) rdata = shd_tb.period;
        if (addr_hit(addr, OFS_SYNC))   rdata = {{(PWM_DW-1){1'b0}}, sync_mode};
        for (int g = 0; g < NUM_GRP; g++) begin
            if (addr_hit(addr, OFS_EN_BASE + g * OFS_EN_STEP))
                rdata = en_q[g*PWM_GRP_W +: PWM_GRP_W];
        end
        for (int ch = 0; ch < NUM_CH; ch++) begin
            if (addr_hit(addr, OFS_EDGE + ch * EDGE_STRIDE))
                rdata = shd_edges[ch].rise;
            if (addr_hit(addr, OFS_EDGE + ch * EDGE_STRIDE + FALL_OFS))
                rdata = shd_edges[ch].fall;
        end
    end

endmodule

// File: rtl/pwm_edge_timebase.sv
module pwm_edge_timebase
    import pwm_edge_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  pwm_tb_cfg_t cfg,
    output pwm_val_t    step,
    output pwm_val_t    presc_cnt,
    output logic        period_end
);

    logic tick;

    assign tick       = presc_cnt >= cfg.presc;
    assign period_end = tick && (step >= cfg.period);

    always_ff @(posedge clk) begin
        if (rst) begin
            presc_cnt <= '0;
            step      <= '0;
        end else begin
            presc_cnt <= tick ? '0 : presc_cnt + 1'b1;
            if (tick)
                step <= (step >= cfg.period) ? '0 : step + 1'b1;
        end
    end

endmodule

// File: rtl/pwm_edge_chan.sv
module pwm_edge_chan
    import pwm_edge_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  pwm_val_t   step,
    input  pwm_edges_t edges,
    output logic       out
);

    always_ff @(posedge clk) begin
        if (rst) out <= 1'b0;
        else     out <= en && pwm_level(step, edges);
    end

endmodule

// File: rtl/pwm_edge_ctrl.sv
module pwm_edge_ctrl
    import pwm_edge_pkg::*;
#(
    parameter int NUM_CH = 16
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [PWM_AW-1:0] paddr,
    input  logic [PWM_DW-1:0] pwdata,
    output logic [PWM_DW-1:0] prdata,
    output logic [NUM_CH-1:0] pwm_out
);

    localparam int NUM_GRP = (NUM_CH + PWM_GRP_W - 1) / PWM_GRP_W;

    pwm_tb_cfg_t             shd_tb, act_tb;
    pwm_edges_t [NUM_CH-1:0] shd_edges, act_edges;
    logic [NUM_CH-1:0]       chan_en;
    logic                    sync_mode;
    logic                    period_end;
    pwm_val_t                step, presc_cnt;
    logic                    wr_en;

    assign wr_en = psel && penable && pwrite;

    pwm_edge_regs #(.NUM_CH(NUM_CH), .NUM_GRP(NUM_GRP)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(paddr), .wdata(pwdata),
        .rdata(prdata), .shd_tb(shd_tb), .shd_edges(shd_edges),
        .chan_en(chan_en), .sync_mode(sync_mode)
    );

    // Shadow to active transfer: every clock, or only at a period end.
    always_ff @(posedge clk) begin
        if (rst) begin
            act_tb    <= '0;
            act_edges <= '0;
        end else if (!sync_mode || period_end) begin
            act_tb    <= shd_tb;
            act_edges <= shd_edges;
        end
    end

    pwm_edge_timebase u_tb (
        .clk(clk), .rst(rst), .cfg(act_tb), .step(step),
        .presc_cnt(presc_cnt), .period_end(period_end)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
        pwm_edge_chan u_chan (
            .clk(clk), .rst(rst), .en(chan_en[i]), .step(step),
            .edges(act_edges[i]), .out(pwm_out[i])
        );
    end

endmodule

// File: rtl/pwm_edge_ctrl_chk.sv
module pwm_edge_ctrl_chk
    import pwm_edge_pkg::*;
#(
    parameter int NUM_CH = 16
)(
    input logic                    clk,
    input logic                    rst,
    input logic [NUM_CH-1:0]       pwm_out,
    input logic [NUM_CH-1:0]       chan_en,
    input logic                    sync_mode,
    input logic                    period_end,
    input pwm_val_t                step,
    input pwm_val_t                presc_cnt,
    input pwm_tb_cfg_t             act_tb,
    input pwm_tb_cfg_t             shd_tb,
    input pwm_edges_t [NUM_CH-1:0] act_edges,
    input pwm_edges_t [NUM_CH-1:0] shd_edges
);

    AST_OFF_IS_LOW: assert property (@(posedge clk) disable iff (rst)
        (pwm_out & ~$past(chan_en)) == '0); // R8

    AST_STEP_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        (step != $past(step)) |-> ($past(presc_cnt) >= $past(act_tb.presc))); // R4

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        period_end |=> (step == '0)); // R4

    AST_IMMEDIATE_COPY: assert property (@(posedge clk) disable iff (rst)
        !sync_mode |=> (act_tb == $past(shd_tb)) && (act_edges == $past(shd_edges))); // R10

    AST_SYNC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (sync_mode && !period_end) |=> ($stable(act_tb) && $stable(act_edges))); // R11

    for (genvar i = 0; i < NUM_CH; i++) begin : g_eq
        AST_EQUAL_LOW: assert property (@(posedge clk) disable iff (rst)
            ($past(act_edges[i].rise) == $past(act_edges[i].fall)) |-> !pwm_out[i]); // R7
    end

endmodule

bind pwm_edge_ctrl pwm_edge_ctrl_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk(clk), .rst(rst), .pwm_out(pwm_out), .chan_en(chan_en),
    .sync_mode(sync_mode), .period_end(period_end), .step(step),
    .presc_cnt(presc_cnt), .act_tb(act_tb), .shd_tb(shd_tb),
    .act_edges(act_edges), .shd_edges(shd_edges)
);

// File: tb/tb_pwm_edge_ctrl.sv
module tb_pwm_edge_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0, pwdata = '0;
    logic [7:0]  prdata;
    logic [15:0] pwm_out;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #10 clk = ~clk;   // 50 MHz
    always @(posedge clk) cyc <= cyc + 1;

    pwm_edge_ctrl dut (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pwm_out(pwm_out)
    );

    typedef struct packed {
        logic [7:0] presc;
        logic [7:0] period;
        logic [7:0] rise;
        logic [7:0] fall;
        logic [3:0] ch;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{8'd0, 8'd9,   8'd0,   8'd4,   4'd0},
        '{8'd2, 8'd7,   8'd2,   8'd6,   4'd5},
        '{8'd1, 8'd15,  8'd10,  8'd3,   4'd9},
        '{8'd0, 8'd5,   8'd5,   8'd0,   4'd3},
        '{8'd3, 8'd4,   8'd1,   8'd4,   4'd12},
        '{8'd0, 8'd255, 8'd0,   8'd128, 4'd15},
        '{8'd0, 8'd1,   8'd1,   8'd0,   4'd7}
    };

    function automatic int exp_period(int p, int n);
        return (p + 1) * (n + 1);
    endfunction

    function automatic int exp_high(int p, int n, int r, int f);
        if (r < f) return (f - r) * (p + 1);
        if (f < r) return (n + 1 - (r - f)) * (p + 1);
        return 0;
    endfunction

    function automatic logic [7:0] rise_ofs(int ch);
        return 8'(16 + 8 * ch);
    endfunction

    function automatic logic [7:0] fall_ofs(int ch);
        return 8'(20 + 8 * ch);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic apb_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
        #1 d = prdata;
        psel = 1'b0;
    endtask

    task automatic wait_rise(input int ch);
        logic prev;
        prev = pwm_out[ch];
        for (int k = 0; k < 4000; k++) begin
            @(negedge clk);
            if (!prev && pwm_out[ch]) return;
            prev = pwm_out[ch];
        end
    endtask

    task automatic wait_fall(input int ch);
        logic prev;
        prev = pwm_out[ch];
        for (int k = 0; k < 4000; k++) begin
            @(negedge clk);
            if (prev && !pwm_out[ch]) return;
            prev = pwm_out[ch];
        end
    endtask

    task automatic measure(input int ch, output int per, output int hi);
        logic prev;
        wait_rise(ch);
        wait_rise(ch);
        per = 1; hi = 1; prev = 1'b1;
        while (per < 4000) begin
            @(negedge clk);
            if (!prev && pwm_out[ch]) break;
            if (pwm_out[ch]) hi++;
            prev = pwm_out[ch];
            per++;
        end
    endtask

    task automatic count_high(input int ch, input int n, output int hi);
        hi = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (pwm_out[ch]) hi++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        int per, hi, t0, mism;

        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk(pwm_out == 16'h0, "R1 outputs", int'(pwm_out), 0);
        apb_read(8'h00, rd); chk(rd == 0, "R1 prescale", rd, 0);
        apb_read(8'h04, rd); chk(rd == 0, "R1 period", rd, 0);
        apb_read(8'h08, rd); chk(rd == 0, "R1 enable lo", rd, 0);
        apb_read(8'h0C, rd); chk(rd == 0, "R1 enable hi", rd, 0);
        apb_read(fall_ofs(15), rd); chk(rd == 0, "R1 fall ch15", rd, 0);
        apb_read(8'hE4, rd); chk(rd == 0, "R1 sync", rd, 0);

        // Vector table: R2 readback, R4 period, R5 / R6 high time
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VECS[i];
            apb_write(8'h08, 8'h00);
            apb_write(8'h0C, 8'h00);
            apb_write(8'h00, v.presc);
            apb_write(8'h04, v.period);
            apb_write(rise_ofs(int'(v.ch)), v.rise);
            apb_write(fall_ofs(int'(v.ch)), v.fall);
            apb_read(rise_ofs(int'(v.ch)), rd); chk(rd == v.rise, "R2 rise readback", rd, v.rise);
            apb_read(fall_ofs(int'(v.ch)), rd); chk(rd == v.fall, "R2 fall readback", rd, v.fall);
            apb_read(8'h04, rd); chk(rd == v.period, "R2 period readback", rd, v.period);
            if (v.ch < 8) apb_write(8'h08, 8'(1 << v.ch));
            else          apb_write(8'h0C, 8'(1 << (v.ch - 8)));
            measure(int'(v.ch), per, hi);
            chk(per == exp_period(v.presc, v.period), "R4 period length", per,
                exp_period(v.presc, v.period));
            if (v.rise < v.fall)
                chk(hi == exp_high(v.presc, v.period, v.rise, v.fall), "R5 high time", hi,
                    exp_high(v.presc, v.period, v.rise, v.fall));
            else
                chk(hi == exp_high(v.presc, v.period, v.rise, v.fall), "R6 inverted high time", hi,
                    exp_high(v.presc, v.period, v.rise, v.fall));
        end

        // R3: unmapped offsets
        apb_write(8'h00, 8'h03);
        apb_write(8'hA0, 8'h5A);
        apb_write(8'h02, 8'h77);
        apb_read(8'hA0, rd); chk(rd == 0, "R3 unmapped read", rd, 0);
        apb_read(8'h02, rd); chk(rd == 0, "R3 misaligned read", rd, 0);
        apb_read(8'hE8, rd); chk(rd == 0, "R3 unmapped read E8", rd, 0);
        apb_read(8'h00, rd); chk(rd == 8'h03, "R3 prescale untouched", rd, 3);

        // R8: disabled channel stays low, then runs once enabled
        apb_write(8'h08, 8'h00);
        apb_write(8'h0C, 8'h00);
        apb_write(8'h00, 8'd0);
        apb_write(8'h04, 8'd9);
        apb_write(rise_ofs(3), 8'd0);
        apb_write(fall_ofs(3), 8'd5);
        count_high(3, 100, hi); chk(hi == 0, "R8 disabled low", hi, 0);
        apb_write(8'h08, 8'h08);
        @(negedge clk);
        count_high(3, 100, hi); chk(hi == 50, "R8 enabled runs", hi, 50);

        // R7: equal edges stay low
        apb_write(rise_ofs(4), 8'd3);
        apb_write(fall_ofs(4), 8'd3);
        apb_write(8'h08, 8'h10);
        count_high(4, 100, hi); chk(hi == 0, "R7 equal edges low", hi, 0);

        // R11: sync-update defers a fall change to the period end
        apb_write(8'h08, 8'h00);
        apb_write(8'h04, 8'd99);
        apb_write(rise_ofs(0), 8'd0);
        apb_write(fall_ofs(0), 8'd50);
        apb_write(8'hE4, 8'h01);
        apb_read(8'hE4, rd); chk(rd == 8'h01, "R2 sync readback", rd, 1);
        apb_write(8'h08, 8'h01);
        wait_rise(0); wait_rise(0);
        t0 = cyc;
        repeat (8) @(negedge clk);
        apb_write(fall_ofs(0), 8'd20);
        wait_fall(0);
        chk(cyc - t0 == 50, "R11 current pulse keeps old fall", cyc - t0, 50);
        wait_rise(0); t0 = cyc; wait_fall(0);
        chk(cyc - t0 == 20, "R11 next pulse uses new fall", cyc - t0, 20);

        // R10: immediate mode applies a fall change mid-pulse
        apb_write(8'hE4, 8'h00);
        apb_write(fall_ofs(0), 8'd50);
        wait_rise(0); wait_rise(0);
        t0 = cyc;
        repeat (8) @(negedge clk);
        apb_write(fall_ofs(0), 8'd20);
        wait_fall(0);
        chk(cyc - t0 == 20, "R10 immediate fall change", cyc - t0, 20);

        // R9: late enable joins the running phase
        apb_write(rise_ofs(1), 8'd0);
        apb_write(fall_ofs(1), 8'd50);
        apb_write(rise_ofs(2), 8'd0);
        apb_write(fall_ofs(2), 8'd50);
        apb_write(8'h08, 8'h02);
        wait_rise(1); wait_rise(1);
        repeat (20) @(negedge clk);
        apb_write(8'h08, 8'h06);
        @(negedge clk);
        chk(pwm_out[2] == 1'b1, "R9 high at once mid-pulse", int'(pwm_out[2]), 1);
        mism = 0;
        for (int k = 0; k < 250; k++) begin
            @(negedge clk);
            if (pwm_out[2] != pwm_out[1]) mism++;
        end
        chk(mism == 0, "R9 in phase with running channel", mism, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule